// File: doc/BRIEF.md
# Requester-to-Stream ID Translation Table

This block sits between a PCIe root port and an IOMMU. Each transaction that arrives from a downstream device carries a 16-bit requester ID (bus, device, function). The IOMMU, however, works with stream IDs. The block keeps a small table of programmed pairs and translates a requester ID to its stream ID. Software fills the table through a word-wide register port. The translation side takes a requester ID and answers one cycle later with a hit flag and the stream ID.

Each table slot is one 32-bit word: a valid flag on top, the stream ID in the middle and the requester ID in the low half. The register window is sized for 64 slots, but only a parameterised number of them have storage. The slots without storage read as zero and drop writes. Software can therefore find the real table size by writing a marker pattern to each slot in turn and stopping at the first slot that does not read the marker back.

Top module: `rsm_table`

## Requirements
- R1: After a synchronous reset every slot reads as zero, which means invalid. `lk_ack`, `lk_hit`, `lk_sid` and `reg_rvalid` are all low or zero.
- R2: A read strobe returns the addressed word on `reg_rdata`, with `reg_rvalid` high, on the cycle after the strobe. A word written to an implemented slot reads back unchanged.
- R3: Slot i sits at byte address 0x828 + 4*i, for i from 0 to 63. Slots at or above the implemented count (`NUM_IMPL`) read as zero and ignore writes.
- R4: Addresses below 0x828, addresses at or above 0x928, and addresses whose low two bits are not zero hit no slot. Reads of them return zero and writes to them change no slot.
- R5: A slot word holds the valid flag in bit 31, the stream ID in bits 30:16 and the requester ID in bits 15:0. The requester ID carries the bus in bits 15:8, the device in bits 7:3 and the function in bits 2:0.
- R6: A lookup strobe `lk_req` with `lk_rid` is answered on the next cycle. If a valid slot has a requester ID equal to `lk_rid`, `lk_hit` is high and `lk_sid` equals bits 30:16 of that slot.
- R7: A slot with bit 31 clear never matches, even when its requester ID equals `lk_rid`. Writing zero to a slot invalidates it.
- R8: When several valid slots match, the one with the lowest index supplies the stream ID.
- R9: When no valid slot matches, `lk_hit` is low and `lk_sid` is zero.
- R10: `lk_ack` is high exactly on the cycle after a `lk_req`. On any cycle where `lk_ack` is low, `lk_hit` and `lk_sid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd_en |
| lk_req | input | 1 | Lookup strobe |
| lk_rid | input | 16 | Requester ID to translate |
| lk_ack | output | 1 | Lookup answer valid |
| lk_hit | output | 1 | A valid slot matched |
| lk_sid | output | 15 | Stream ID of the winning slot, zero on a miss |

## Verification
Both results of the block are due exactly one clock edge after their strobe. Register read data appears the cycle after `reg_rd_en`, and the lookup answer appears the cycle after `lk_req`. The bench drives each strobe on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. Every check therefore sees the single registered stage and never sees a neighbouring cycle. A lookup reads the table as it stood before any write in the same cycle. A read likewise returns the word as it stood before a write in the same cycle. The bench keeps writes and the accesses that depend on them in separate cycles, so the expected value is the state after the last completed write.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    localparam int RID_W   = 16;
    localparam int SID_W   = 15;
    localparam int WORD_W  = 1 + SID_W + RID_W;
    localparam int ADDR_W  = 12;
    localparam int BASE    = 'h828;

    typedef struct packed {
        logic             vld;
        logic [SID_W-1:0] sid;
        logic [RID_W-1:0] rid;
    } rsm_entry_t;

    function automatic logic [RID_W-1:0] make_rid(input logic [7:0] bus,
                                                  input logic [4:0] dev,
                                                  input logic [2:0] fn);
        return {bus, dev, fn};
    endfunction

endpackage

// File: rtl/rsm_regif.sv
module rsm_regif
    import rsm_pkg::*;
#(
    parameter int MAX_ENTRIES = 64,
    parameter int NUM_IMPL    = 8,
    localparam int IDX_W      = $clog2(MAX_ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  rsm_entry_t [NUM_IMPL-1:0] ents,
    output logic                     wr_sel,
    output logic [IDX_W-1:0]         wr_idx,
    output logic [WORD_W-1:0]        rdata,
    output logic                     rvalid
);
    localparam int WIN_BYTES = 4 * MAX_ENTRIES;

    logic [ADDR_W-1:0] off;
    logic              in_win;
    logic              impl_sel;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        off      = addr - ADDR_W'(BASE);
        in_win   = (addr >= ADDR_W'(BASE)) && (off < ADDR_W'(WIN_BYTES))
                   && (off[1:0] == 2'b00);
        idx      = off[IDX_W+1:2];
        impl_sel = in_win && ({1'b0, idx} < (IDX_W+1)'(NUM_IMPL));
    end

    always_comb begin
        rd_word = '0;
        for (int g = 0; g < NUM_IMPL; g++) begin
            if (impl_sel && idx == IDX_W'(g)) rd_word = ents[g];
        end
    end

    assign wr_sel = wr_en && impl_sel;
    assign wr_idx = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? rd_word : '0;
        end
    end

    // R3 / R4: an access that selects no storage returns zero
    a_r4_unselected_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !impl_sel) |=> (rdata == '0));

    a_r2_rvalid_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);

endmodule

// File: rtl/rsm_bank.sv
module rsm_bank
    import rsm_pkg::*;
#(
    parameter int MAX_ENTRIES = 64,
    parameter int NUM_IMPL    = 8,
    localparam int IDX_W      = $clog2(MAX_ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_sel,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [WORD_W-1:0]         wdata,
    output rsm_entry_t [NUM_IMPL-1:0] ents
);
    for (genvar g = 0; g < NUM_IMPL; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                ents[g] <= '0;
            else if (wr_sel && wr_idx == IDX_W'(g))
                ents[g] <= rsm_entry_t'(wdata);
        end

        // R2: a slot changes only when it is the write target
        a_r2_slot_holds: assert property (@(posedge clk) disable iff (rst)
            !(wr_sel && wr_idx == IDX_W'(g)) |=> $stable(ents[g]));
    end

endmodule

// File: rtl/rsm_match.sv
module rsm_match
    import rsm_pkg::*;
#(
    parameter int NUM_IMPL = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req,
    input  logic [RID_W-1:0]          rid,
    input  rsm_entry_t [NUM_IMPL-1:0] ents,
    output logic                      ack,
    output logic                      hit,
    output logic [SID_W-1:0]          sid
);
    logic [NUM_IMPL-1:0] hit_vec;
    logic [NUM_IMPL-1:0] win_vec;
    logic [SID_W-1:0]    sid_c;

    for (genvar g = 0; g < NUM_IMPL; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].vld && (ents[g].rid == rid);
    end

    // isolate the lowest set bit: lowest index has priority
    assign win_vec = hit_vec & (~hit_vec + NUM_IMPL'(1));

    always_comb begin
        sid_c = '0;
        for (int g = 0; g < NUM_IMPL; g++) begin
            if (win_vec[g]) sid_c = sid_c | ents[g].sid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
            hit <= 1'b0;
            sid <= '0;
        end else begin
            ack <= req;
            hit <= req && (|hit_vec);
            sid <= req ? sid_c : '0;
        end
    end

    a_r8_single_winner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_vec));

    a_r6_hit_needs_request: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(req));

endmodule

// File: rtl/rsm_table.sv
module rsm_table
    import rsm_pkg::*;
#(
    parameter int MAX_ENTRIES = 64,
    parameter int NUM_IMPL    = 8,
    localparam int IDX_W      = $clog2(MAX_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic              lk_req,
    input  logic [15:0]       lk_rid,
    output logic              lk_ack,
    output logic              lk_hit,
    output logic [14:0]       lk_sid
);
    rsm_entry_t [NUM_IMPL-1:0] ents;
    logic                      wr_sel;
    logic [IDX_W-1:0]          wr_idx;

    rsm_regif #(.MAX_ENTRIES(MAX_ENTRIES), .NUM_IMPL(NUM_IMPL)) u_regif (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
        .addr(reg_addr), .ents(ents), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .rdata(reg_rdata), .rvalid(reg_rvalid));

    rsm_bank #(.MAX_ENTRIES(MAX_ENTRIES), .NUM_IMPL(NUM_IMPL)) u_bank (
        .clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wdata(reg_wdata), .ents(ents));

    rsm_match #(.NUM_IMPL(NUM_IMPL)) u_match (
        .clk(clk), .rst(rst), .req(lk_req), .rid(lk_rid), .ents(ents),
        .ack(lk_ack), .hit(lk_hit), .sid(lk_sid));

    a_r10_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> lk_ack);

    a_r10_quiet_without_ack: assert property (@(posedge clk) disable iff (rst)
        !lk_ack |-> (!lk_hit && lk_sid == '0));

    a_r9_miss_gives_zero: assert property (@(posedge clk) disable iff (rst)
        (lk_ack && !lk_hit) |-> (lk_sid == '0));

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lk_ack && !reg_rvalid && ents == '0));

endmodule

// File: tb/tb_rsm_table.sv
module tb_rsm_table;
    localparam int CLK_PERIOD = 10;
    localparam int MAXE       = 64;
    localparam int IMPL       = 8;
    localparam int BASE       = 'h828;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        lk_req = 1'b0;
    logic [15:0] lk_rid = '0;
    logic        lk_ack, lk_hit;
    logic [14:0] lk_sid;

    int total = 0;
    int bad   = 0;
    logic [31:0] model [MAXE];

    rsm_table #(.MAX_ENTRIES(MAXE), .NUM_IMPL(IMPL)) dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .lk_req(lk_req), .lk_rid(lk_rid),
        .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_sid(lk_sid));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] slot_addr(input int i);
        return 12'(BASE + 4 * i);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a >= 12'(BASE) && a < 12'(BASE + 4*MAXE) && a[1:0] == 2'b00
            && ((int'(a) - BASE) / 4) < IMPL)
            model[(int'(a) - BASE) / 4] = d;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
        reg_addr = a; reg_rd_en = 1'b1;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata; v = reg_rvalid;
    endtask

    task automatic lookup_check(input string req, input logic [15:0] rid);
        logic        eh;
        logic [14:0] es;
        eh = 1'b0; es = '0;
        for (int i = 0; i < MAXE; i++) begin
            if (!eh && model[i][31] && model[i][15:0] == rid) begin
                eh = 1'b1; es = model[i][30:16];
            end
        end
        lk_rid = rid; lk_req = 1'b1;
        @(negedge clk);
        lk_req = 1'b0;
        check({req, " ack"}, 32'(lk_ack), 32'(1));
        check({req, " hit"}, 32'(lk_hit), 32'(eh));
        check({req, " sid"}, 32'(lk_sid), 32'(es));
    endtask

    function automatic logic [15:0] rid_of(input int bus, input int dev, input int fn);
        return 16'(bus * 256 + dev * 8 + fn);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        logic        v;
        int          found;
        for (int i = 0; i < MAXE; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 ack", 32'(lk_ack), 0);
        check("R1 hit", 32'(lk_hit), 0);
        check("R1 rvalid", 32'(reg_rvalid), 0);
        for (int i = 0; i < IMPL; i++) begin
            rd(slot_addr(i), d, v);
            check("R1 slot zero", d, 0);
        end

        // R2 / R3: size probe with a marker over the whole window
        found = 0;
        for (int i = 0; i < MAXE; i++) begin
            wr(slot_addr(i), 32'h000bad1d);
            rd(slot_addr(i), d, v);
            check("R2 rvalid", 32'(v), 1);
            check("R3 probe readback", d, (i < IMPL) ? 32'h000bad1d : 32'h0);
            if (d == 32'h000bad1d && found == i) found++;
            wr(slot_addr(i), 32'h0);
            rd(slot_addr(i), d, v);
            check("R7 zero write clears", d, 0);
        end
        check("R3 probed size", 32'(found), 32'(IMPL));

        // R4: outside window and misaligned
        wr(12'h824, 32'hffffffff);
        wr(12'h928, 32'hffffffff);
        wr(12'h82a, 32'hffffffff);
        wr(12'h82d, 32'hffffffff);
        rd(12'h824, d, v); check("R4 below window", d, 0);
        rd(12'h928, d, v); check("R4 above window", d, 0);
        rd(12'h82a, d, v); check("R4 misaligned read", d, 0);
        rd(slot_addr(0), d, v); check("R4 slot0 untouched", d, 0);
        rd(slot_addr(1), d, v); check("R4 slot1 untouched", d, 0);

        // R5 / R6: program every implemented slot
        for (int i = 0; i < IMPL; i++) begin
            wr(slot_addr(i), {1'b1, 15'(16'h100 + 3*i), rid_of(i + 1, (5*i) % 32, i % 8)});
        end
        for (int i = 0; i < IMPL; i++) begin
            rd(slot_addr(i), d, v);
            check("R2 readback", d, {1'b1, 15'(16'h100 + 3*i), rid_of(i + 1, (5*i) % 32, i % 8)});
            lookup_check("R6 hit", rid_of(i + 1, (5*i) % 32, i % 8));
        end
        // R5: full-width stream ID lands in bits 30:16
        wr(slot_addr(0), {1'b1, 15'h7abc, rid_of(200, 31, 7)});
        lookup_check("R5 field position", rid_of(200, 31, 7));

        // R7: invalid slot with matching requester ID
        wr(slot_addr(3), {1'b0, 15'h1234, rid_of(77, 2, 1)});
        lookup_check("R7 invalid slot", rid_of(77, 2, 1));

        // R8: duplicates, lowest index wins
        wr(slot_addr(IMPL-1), {1'b1, 15'h0055, rid_of(3, 10, 2)});
        lookup_check("R8 priority", rid_of(3, 10, 2));
        wr(slot_addr(2), 32'h0);
        lookup_check("R8 next takes over", rid_of(3, 10, 2));

        // R9: sweep a span of requester IDs against the model
        for (int r = 0; r < 2304; r++) begin
            lookup_check("R9 sweep", 16'(r));
        end

        // R10: ack only after a strobe
        @(negedge clk);
        check("R10 ack idle", 32'(lk_ack), 0);
        check("R10 hit idle", 32'(lk_hit), 0);
        check("R10 sid idle", 32'(lk_sid), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule